// File: doc/BRIEF.md
# Block Floating Point Scaling Unit

This unit manages the exponent of a multi-pass FFT. While a pass writes its results, the unit watches every complex result. It finds the smallest count of redundant sign bits among the real and imaginary parts. That count measures the headroom of the largest-magnitude result. At the end of each pass it chooses a left-shift amount for the data of the next pass and adds that amount to a running exponent for the whole transform.

When the final pass ends, the accumulated exponent is published as a 4-bit scale tag together with a one-cycle valid pulse. The growth mode is sampled when the transform starts. With three bits of word growth per pass, overflow cannot occur and every tag value is a shift count. With two bits of growth, the datapath may report overflow. In that mode the shift total stops at 14, tag value 15 means the transform overflowed, and a zero-force control blanks all output bins.

Top module: `bfp_scaler`

## Requirements
- R1: The redundant sign-bit count of a 16-bit two's-complement value is the number of bits below the MSB that equal the MSB, counted from bit 14 downward until the first bit that differs. Values 0 and -1 count 15. The pass minimum is taken over both components of every result with `res_vld` high, from the `pass_start` cycle through the `pass_end` cycle inclusive.
- R2: On a `pass_end` with `pass_last` low, `shift_amt` takes, one cycle later, the smallest of three values: the pass minimum, 4, and the remaining exponent headroom. `shift_amt` changes only on `pass_end` or `xfm_start`. On the final `pass_end` it returns to 0.
- R3: Every non-final shift amount is added to the running exponent. On the final `pass_end`, the next cycle shows `scale_tag` equal to the exponent and `tag_vld` high for exactly one cycle. `scale_tag` then holds until the next final pass.
- R4: In two-bit growth mode (`grow3`=0 at `xfm_start`), the exponent never exceeds 14.
- R5: In two-bit growth mode, `res_ovf` high together with `res_vld` sets `ovf_flag` on the next cycle. The flag stays set until `xfm_start`. At the final `pass_end` of an overflowed transform, `scale_tag` becomes 15 and `zero_bins` rises. `zero_bins` holds until `xfm_start`.
- R6: In three-bit growth mode (`grow3`=1), the exponent may reach 15 as a normal count, and `res_ovf` has no effect on `ovf_flag`, `scale_tag` or `zero_bins`.
- R7: `xfm_start` clears the exponent, `shift_amt`, `ovf_flag` and `zero_bins`, and samples `grow3` as the mode of the new transform.
- R8: `pass_start` restarts the sign-bit tracker at 15. A pass whose results are all zero therefore yields a shift of 4, never more.
- R9: After reset, `shift_amt`, `scale_tag`, `tag_vld`, `ovf_flag` and `zero_bins` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfm_start | input | 1 | Transform start strobe; clears the exponent and samples the mode |
| grow3 | input | 1 | 1 = three-bit word growth, 0 = two-bit word growth |
| pass_start | input | 1 | First cycle of a pass |
| pass_end | input | 1 | Last cycle of a pass |
| pass_last | input | 1 | Qualifies `pass_end` as the end of the final pass |
| res_vld | input | 1 | A result is present on `res_re`/`res_im` |
| res_re | input | 16 | Real component of the result, signed |
| res_im | input | 16 | Imaginary component of the result, signed |
| res_ovf | input | 1 | Datapath reports overflow for this result |
| shift_amt | output | 3 | Left shift to apply to the data of the next pass |
| scale_tag | output | 4 | Total left shifts of the transform, or 15 for overflow in two-bit mode |
| tag_vld | output | 1 | One-cycle pulse when `scale_tag` is updated |
| ovf_flag | output | 1 | Sticky overflow indicator for the current transform |
| zero_bins | output | 1 | Forces all output frequency bins to zero |

## Verification
The bench builds the unit with its default parameters: 16-bit components, at most 4 shifts per pass and a 4-bit tag. With these values, four all-zero passes are enough to drive the exponent to its cap of 14 or 15. This makes the cap, the clipped last step and the overflow code reachable in a few hundred cycles. Values such as -1, -32768 and a result presented on the `pass_end` cycle itself exercise the extremes of the sign-bit count.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  typedef enum logic {
    GROW_2 = 1'b0,
    GROW_3 = 1'b1
  } growth_e;

  // smallest of three non-negative counts
  function automatic int min3(int a, int b, int c);
    int m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  // shifts still allowed before the exponent reaches the mode's cap
  function automatic int headroom(int top, growth_e mode, int expo);
    int cap;
    cap = (mode == GROW_3) ? top : top - 1;
    return (cap > expo) ? cap - expo : 0;
  endfunction

endpackage

// File: rtl/bfp_sign_tracker.sv
module bfp_sign_tracker #(
  parameter int DW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pass_start,
  input  logic          res_vld,
  input  logic [DW-1:0] res_re,
  input  logic [DW-1:0] res_im,
  output logic [NW-1:0] pass_min
);

  localparam logic [NW-1:0] EMPTY = NW'(DW - 1);

  // bits below the MSB that repeat it, scanning downward
  function automatic logic [NW-1:0] sign_count(logic [DW-1:0] x);
    logic [NW-1:0] cnt;
    logic          run;
    cnt = '0;
    run = 1'b1;
    for (int i = DW - 2; i >= 0; i--) begin
      if (run && (x[i] == x[DW-1])) cnt = cnt + NW'(1);
      else run = 1'b0;
    end
    return cnt;
  endfunction

  logic [DW-1:0] comp   [2];
  logic [NW-1:0] lane_n [2];
  logic [NW-1:0] sample_n;
  logic [NW-1:0] base_n;
  logic [NW-1:0] trk_q;

  assign comp[0] = res_re;
  assign comp[1] = res_im;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign lane_n[g] = sign_count(comp[g]);
    end
  endgenerate

  always_comb begin
    if (!res_vld)                sample_n = EMPTY;
    else if (lane_n[0] < lane_n[1]) sample_n = lane_n[0];
    else                         sample_n = lane_n[1];
    base_n   = pass_start ? EMPTY : trk_q;
    pass_min = (sample_n < base_n) ? sample_n : base_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_q <= EMPTY;
    else        trk_q <= pass_min;
  end

  // R1: within a pass the tracked count can only fall
  p_min_falls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_start) |=> (trk_q <= $past(trk_q)));

  // R8: a pass start without a result restarts the tracker at its top
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !res_vld) |=> (trk_q == EMPTY));

endmodule

// File: rtl/bfp_ovf_guard.sv
module bfp_ovf_guard
  import bfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    xfm_start,
  input  growth_e mode_q,
  input  logic    res_vld,
  input  logic    res_ovf,
  input  logic    tag_evt,
  output logic    ovf_now,
  output logic    ovf_seen,
  output logic    zero_bins
);

  logic hit;

  assign hit     = res_vld && res_ovf && (mode_q == GROW_2);
  assign ovf_now = ovf_seen || hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_seen  <= 1'b0;
      zero_bins <= 1'b0;
    end else if (xfm_start) begin
      ovf_seen  <= 1'b0;
      zero_bins <= 1'b0;
    end else begin
      ovf_seen <= ovf_now;
      if (tag_evt) zero_bins <= ovf_now;
    end
  end

  // R6: three-bit growth never records overflow
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == GROW_3) |-> !ovf_seen);

  // R5: an overflowed transform blanks the bins when it ends
  p_zero_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_evt && ovf_now) |=> zero_bins);

  // R7: start clears the overflow state
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfm_start |=> (!ovf_seen && !zero_bins));

endmodule

// File: rtl/bfp_step_ctrl.sv
module bfp_step_ctrl
  import bfp_pkg::*;
#(
  parameter int NW       = 4,
  parameter int TAG_W    = 4,
  parameter int MAX_STEP = 4,
  parameter int STEP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfm_start,
  input  logic              grow3,
  input  logic              pass_end,
  input  logic              pass_last,
  input  logic [NW-1:0]     pass_min,
  input  logic              ovf_now,
  output growth_e           mode_q,
  output logic              tag_evt,
  output logic [STEP_W-1:0] shift_amt,
  output logic [TAG_W-1:0]  scale_tag,
  output logic              tag_vld
);

  localparam int TOP = (1 << TAG_W) - 1;

  logic [TAG_W-1:0]  exp_q;
  logic [STEP_W-1:0] step_next;
  logic              step_evt;

  assign tag_evt  = pass_end && pass_last && !xfm_start;
  assign step_evt = pass_end && !pass_last && !xfm_start;
  assign step_next = STEP_W'(min3(int'(pass_min), MAX_STEP,
                                  headroom(TOP, mode_q, int'(exp_q))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q     <= '0;
      mode_q    <= GROW_2;
      shift_amt <= '0;
      scale_tag <= '0;
      tag_vld   <= 1'b0;
    end else begin
      tag_vld <= 1'b0;
      if (xfm_start) begin
        exp_q     <= '0;
        shift_amt <= '0;
        mode_q    <= growth_e'(grow3);
      end else if (tag_evt) begin
        scale_tag <= ovf_now ? TAG_W'(TOP) : exp_q;
        tag_vld   <= 1'b1;
        shift_amt <= '0;
      end else if (step_evt) begin
        shift_amt <= step_next;
        exp_q     <= exp_q + TAG_W'(step_next);
      end
    end
  end

  // R2: per-pass shift stays within its limit
  p_step_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt <= STEP_W'(MAX_STEP));

  // R2: shift amount moves only at pass end or transform start
  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_end && !xfm_start) |=> $stable(shift_amt));

  // R3: the final pass end publishes the tag
  p_tag_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_evt |=> tag_vld);

  // R4: two-bit growth keeps code 15 free for overflow
  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == GROW_2) |-> (exp_q < TAG_W'(TOP)));

  // R7: start clears exponent and shift
  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfm_start |=> (exp_q == '0 && shift_amt == '0));

endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler #(
  parameter int DW       = 16,
  parameter int MAX_STEP = 4,
  parameter int TAG_W    = 4,
  localparam int STEP_W  = $clog2(MAX_STEP + 1),
  localparam int NW      = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfm_start,
  input  logic              grow3,
  input  logic              pass_start,
  input  logic              pass_end,
  input  logic              pass_last,
  input  logic              res_vld,
  input  logic [DW-1:0]     res_re,
  input  logic [DW-1:0]     res_im,
  input  logic              res_ovf,
  output logic [STEP_W-1:0] shift_amt,
  output logic [TAG_W-1:0]  scale_tag,
  output logic              tag_vld,
  output logic              ovf_flag,
  output logic              zero_bins
);

  import bfp_pkg::*;

  logic [NW-1:0] pass_min;
  logic          ovf_now;
  logic          tag_evt;
  growth_e       mode_q;

  bfp_sign_tracker #(.DW(DW), .NW(NW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_start (pass_start),
    .res_vld    (res_vld),
    .res_re     (res_re),
    .res_im     (res_im),
    .pass_min   (pass_min)
  );

  bfp_step_ctrl #(
    .NW(NW), .TAG_W(TAG_W), .MAX_STEP(MAX_STEP), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfm_start (xfm_start),
    .grow3     (grow3),
    .pass_end  (pass_end),
    .pass_last (pass_last),
    .pass_min  (pass_min),
    .ovf_now   (ovf_now),
    .mode_q    (mode_q),
    .tag_evt   (tag_evt),
    .shift_amt (shift_amt),
    .scale_tag (scale_tag),
    .tag_vld   (tag_vld)
  );

  bfp_ovf_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfm_start (xfm_start),
    .mode_q    (mode_q),
    .res_vld   (res_vld),
    .res_ovf   (res_ovf),
    .tag_evt   (tag_evt),
    .ovf_now   (ovf_now),
    .ovf_seen  (ovf_flag),
    .zero_bins (zero_bins)
  );

  // R3: tag valid is a single-cycle pulse
  p_tag_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld && !(pass_end && pass_last)) |=> !tag_vld);

endmodule

// File: tb/test_bfp_scaler.sv
module test_bfp_scaler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfm_start = 1'b0, grow3 = 1'b0;
  logic        pass_start = 1'b0, pass_end = 1'b0, pass_last = 1'b0;
  logic        res_vld = 1'b0, res_ovf = 1'b0;
  logic [15:0] res_re = '0, res_im = '0;
  logic [2:0]  shift_amt;
  logic [3:0]  scale_tag;
  logic        tag_vld, ovf_flag, zero_bins;

  int    vectors = 0, miscompares = 0;
  bit    done = 1'b0;
  string req = "R9";

  always #4 clk = ~clk;

  bfp_scaler i_bfp_scaler (
    .clk(clk), .rst_n(rst_n), .xfm_start(xfm_start), .grow3(grow3),
    .pass_start(pass_start), .pass_end(pass_end), .pass_last(pass_last),
    .res_vld(res_vld), .res_re(res_re), .res_im(res_im), .res_ovf(res_ovf),
    .shift_amt(shift_amt), .scale_tag(scale_tag), .tag_vld(tag_vld),
    .ovf_flag(ovf_flag), .zero_bins(zero_bins)
  );

  // headroom measured from the magnitude's highest set bit
  function automatic int headroom_bits(logic [15:0] v);
    int x;
    x = $signed(v);
    if (x < 0) x = -x - 1;
    if (x == 0) return 15;
    for (int p = 14; p >= 0; p--) if (x >= (1 << p)) return 14 - p;
    return 15;
  endfunction

  // behavioural model
  int m_trk = 15, m_exp = 0, m_shift = 0, m_tag = 0, m_tagv = 0;
  int m_ovf = 0, m_zero = 0, m_mode = 0;

  always @(posedge clk) begin
    int n, cur, s, cap;
    bit onow;
    if (!rst_n) begin
      m_trk = 15; m_exp = 0; m_shift = 0; m_tag = 0; m_tagv = 0;
      m_ovf = 0; m_zero = 0; m_mode = 0;
    end else begin
      n = 15;
      if (res_vld) begin
        n = headroom_bits(res_re);
        if (headroom_bits(res_im) < n) n = headroom_bits(res_im);
      end
      cur = pass_start ? 15 : m_trk;
      if (n < cur) cur = n;
      onow = (m_ovf != 0) || (res_vld && res_ovf && m_mode == 0);
      m_tagv = 0;
      if (xfm_start) begin
        m_exp = 0; m_shift = 0; m_ovf = 0; m_zero = 0; m_mode = grow3;
      end else begin
        if (pass_end && pass_last) begin
          m_tag = onow ? 15 : m_exp; m_tagv = 1; m_zero = onow; m_shift = 0;
        end else if (pass_end) begin
          cap = m_mode ? 15 : 14;
          s = cur;
          if (s > 4) s = 4;
          if (s > cap - m_exp) s = cap - m_exp;
          m_shift = s; m_exp += s;
        end
        m_ovf = onow;
      end
      m_trk = cur;
    end
  end

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      chk("shift_amt", shift_amt, m_shift);
      chk("scale_tag", scale_tag, m_tag);
      chk("tag_vld", tag_vld, m_tagv);
      chk("ovf_flag", ovf_flag, m_ovf);
      chk("zero_bins", zero_bins, m_zero);
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    xfm_start = 0; pass_start = 0; pass_end = 0; pass_last = 0;
    res_vld = 0; res_ovf = 0;
  endtask

  task automatic xfm(bit g3);
    @(posedge clk); #1;
    xfm_start = 1; grow3 = g3; pass_start = 0; pass_end = 0; res_vld = 0; res_ovf = 0;
    idle();
  endtask

  // one pass: start cycle, n results bounded by amp, end cycle with optional result
  task automatic run_pass(int n, int amp, bit last, int ovf_at, bit end_vld, int end_val);
    @(posedge clk); #1;
    pass_start = 1; res_vld = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      pass_start = 0; res_vld = 1;
      res_re = 16'((k * 97 + 13) % (2 * amp + 1) - amp);
      res_im = 16'((k * 61 + 7) % (2 * amp + 1) - amp);
      res_ovf = (k == ovf_at);
    end
    @(posedge clk); #1;
    pass_start = 0; res_ovf = 0; pass_end = 1; pass_last = last;
    res_vld = end_vld; res_re = 16'(end_val); res_im = 16'(0);
    idle();
    idle();
  endtask

  initial begin
    repeat (3) idle();
    rst_n = 1;
    idle();
    req = "R7"; xfm(1);
    req = "R1"; run_pass(12, 300, 0, -1, 0, 0);
    run_pass(12, 20000, 0, -1, 0, 0);
    req = "R2"; run_pass(12, 3000, 0, -1, 0, 0);
    run_pass(10, 5, 0, -1, 0, 0);
    req = "R3"; run_pass(8, 100, 1, -1, 0, 0);
    idle();
    req = "R8"; xfm(1);
    run_pass(6, 0, 0, -1, 0, 0);
    run_pass(6, 0, 0, -1, 0, 0);
    req = "R6"; run_pass(6, 0, 0, 2, 0, 0);
    run_pass(6, 0, 0, -1, 0, 0);
    run_pass(6, 0, 1, 3, 0, 0);
    req = "R4"; xfm(0);
    for (int p = 0; p < 4; p++) run_pass(5, 0, 0, -1, 0, 0);
    run_pass(5, 0, 1, -1, 0, 0);
    req = "R5"; xfm(0);
    run_pass(10, 1000, 0, -1, 0, 0);
    run_pass(10, 1000, 0, 3, 0, 0);
    run_pass(10, 2, 0, -1, 0, 0);
    run_pass(10, 2, 1, -1, 0, 0);
    idle();
    req = "R7"; xfm(1);
    idle();
    req = "R1"; run_pass(8, 0, 0, -1, 1, -32768);
    run_pass(8, 0, 0, -1, 1, -1);
    run_pass(8, 1, 0, -1, 1, 16384);
    req = "R3"; run_pass(4, 0, 1, -1, 0, 0);
    repeat (4) idle();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog %s: actual hung expected finished", req);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule